// File: doc/BRIEF.md
# Call/Return Stack Sequencer

This block performs the memory side of subroutine calls, software breaks and returns for a machine with a 16-bit program counter and a byte-wide data memory. A command arrives together with the current PC, an operand, a table-page bit, the PSW, the stack pointer and the interrupt-enable bit. The block then drives one byte access per clock on a synchronous memory port with one cycle of read latency. Once every result is settled it raises `done` for one cycle and presents the new PC, SP, PSW and interrupt enable, which stay steady until the next command finishes.

Calls push a return address below the stack pointer and take their target from the operand, from a fixed code page, from a two-byte table entry or from memory addressed by a register pair. A break saves the PSW and the return address, then loads the PC from a fixed vector pair. Returns pop the PC, and the interrupt form pops the PSW as well.

Top module: `stk_call_seq`

## Requirements
- R1: Every call (codes 0 direct, 1 page, 2 table, 3 register, 4 register-indirect) writes the return address (PC+3 for code 0, PC+1 for code 2, PC+2 for codes 1, 3 and 4). The high byte goes to SP-1 in the first access cycle and the low byte to SP-2 in the next. The delivered SP is SP-2.
- R2: A page call (code 1) delivers the PC {5'b00001, operand[10:0]}. A direct call (code 0) delivers the operand as the PC.
- R3: A table call (code 2) first does its two pushes. It then reads the new PC low byte at {2'b00, page bit, 8'h00, operand[4:0]} and the high byte at that address plus one.
- R4: A register call (code 3) delivers the operand as the PC. A register-indirect call (code 4) reads the PC low byte at the operand and the high byte at the operand plus one, after its pushes.
- R5: A break (code 5) writes PSW[15:8] to SP-1, PSW[7:0] to SP-2, (PC+1)[15:8] to SP-3 and (PC+1)[7:0] to SP-4, in that order. It delivers SP-4 and leaves the PSW unchanged.
- R6: A break then reads the PC low byte at 0x003E and the high byte at 0x003F, and delivers interrupt enable 0. Every other command passes the interrupt-enable input through.
- R7: A return (code 6) reads the PC low byte at SP and the high byte at SP+1. It delivers SP+2 and leaves the PSW unchanged.
- R8: A return from interrupt (code 7) reads PC low and high at SP and SP+1, then PSW low and high at SP+2 and SP+3. It delivers SP+4.
- R9: There is at most one access per cycle. The first access falls in the cycle after acceptance, and the accesses follow in consecutive cycles. No access occurs while `busy` is low.
- R10: `busy` is high from the cycle after acceptance through one idle cycle after the last access. In the next cycle `done` is high for exactly one cycle. A `start` raised while `busy` is high is ignored.
- R11: Stack addresses and the delivered SP wrap modulo 2^16, with no overflow indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command request, taken when not busy |
| cmd | input | 3 | Command code |
| pc_in | input | 16 | Current program counter |
| opnd | input | 16 | Target, page offset, table index or register pair |
| tbl_page | input | 1 | Table page bit for code 2 |
| psw_in | input | 16 | Current PSW |
| sp_in | input | 16 | Current stack pointer |
| ie_in | input | 1 | Current interrupt enable |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 16 | Byte address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid the cycle after `mem_re` |
| pc_out | output | 16 | New program counter |
| sp_out | output | 16 | New stack pointer |
| psw_out | output | 16 | New PSW |
| ie_out | output | 1 | New interrupt enable |

## Verification
A command accepted at a clock edge produces its N accesses in cycles 1 to N after that edge. Cycle N+1 is a quiet cycle with `busy` still high, and `done` together with all four results is due in cycle N+2. `done` must be low again in cycle N+3. The bench keeps an ordered queue of the expected accesses and compares one entry against the memory port at each falling edge. It checks the quiet cycle, then compares the results and the pulse at exactly those offsets. Expected read data comes from the bench's own memory at the falling edge of the read cycle.

// File: rtl/stk_call_pkg.sv
package stk_call_pkg;
   typedef enum logic [2:0] {
      CMD_CALL_DIR  = 3'd0,
      CMD_CALL_PAGE = 3'd1,
      CMD_CALL_TBL  = 3'd2,
      CMD_CALL_REG  = 3'd3,
      CMD_CALL_RIND = 3'd4,
      CMD_BRK       = 3'd5,
      CMD_RET       = 3'd6,
      CMD_RETI      = 3'd7
   } cmd_e;

   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_WR   = 2'd1,
      ACC_RD   = 2'd2
   } acc_e;

   // bit 1 selects PSW, bit 0 selects the byte lane
   typedef enum logic [1:0] {
      DST_PC_LO  = 2'd0,
      DST_PC_HI  = 2'd1,
      DST_PSW_LO = 2'd2,
      DST_PSW_HI = 2'd3
   } dst_e;
endpackage

// File: rtl/stk_call_tgt.sv
module stk_call_tgt
   import stk_call_pkg::*;
#(
   parameter int AW = 16,
   parameter int PTW = 5,
   parameter logic [PTW-1:0] PTAG = 5'b00001
) (
   input  cmd_e          cmd,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] opnd,
   output logic [AW-1:0] ret,
   output logic [AW-1:0] dest
);
   logic [1:0] len;

   always_comb begin
      unique case (cmd)
         CMD_CALL_DIR:          len = 2'd3;
         CMD_CALL_TBL, CMD_BRK: len = 2'd1;
         CMD_RET, CMD_RETI:     len = 2'd0;
         default:               len = 2'd2;
      endcase
      ret = pc + AW'(len);
      unique case (cmd)
         CMD_CALL_DIR, CMD_CALL_REG: dest = opnd;
         CMD_CALL_PAGE:              dest = {PTAG, opnd[AW-PTW-1:0]};
         default:                    dest = pc;
      endcase
   end
endmodule

// File: rtl/stk_call_plan.sv
module stk_call_plan
   import stk_call_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8,
   parameter int SW = 3,
   parameter int TIW = 5,
   parameter int GAPW = 8,
   parameter logic [AW-1:0] VEC = 16'h003E
) (
   input  cmd_e          cmd,
   input  logic [SW-1:0] step,
   input  logic [AW-1:0] sp,
   input  logic [AW-1:0] ret,
   input  logic [AW-1:0] psw,
   input  logic [AW-1:0] opnd,
   input  logic          page,
   output acc_e          acc,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] wdata,
   output dst_e          dst,
   output logic          last
);
   logic [SW-1:0]   n_push, n_read, rstep;
   logic [2*AW-1:0] push_word;
   logic [AW-1:0]   rbase, tbl_base;
   int              bi;

   always_comb begin
      tbl_base             = '0;
      tbl_base[TIW-1:0]    = opnd[TIW-1:0];
      tbl_base[TIW+GAPW]   = page;
      n_push = SW'(2);
      n_read = SW'(2);
      rbase  = sp;
      unique case (cmd)
         CMD_CALL_TBL:  rbase = tbl_base;
         CMD_CALL_RIND: rbase = opnd;
         CMD_BRK: begin
            n_push = SW'(4);
            rbase  = VEC;
         end
         CMD_RET:  n_push = '0;
         CMD_RETI: begin
            n_push = '0;
            n_read = SW'(4);
         end
         default: n_read = '0;
      endcase
      push_word = (cmd == CMD_BRK) ? {psw, ret} : {{AW{1'b0}}, ret};
      rstep = step - n_push;
      bi    = int'(n_push) - 1 - int'(step);
      acc   = ACC_NONE;
      addr  = '0;
      wdata = '0;
      dst   = DST_PC_LO;
      if (step < n_push) begin
         acc   = ACC_WR;
         addr  = sp - AW'(step) - AW'(1);
         wdata = push_word[bi*DW +: DW];
      end else if (rstep < n_read) begin
         acc  = ACC_RD;
         addr = rbase + AW'(rstep);
         dst  = dst_e'(rstep[1:0]);
      end
      last = (step == n_push + n_read - SW'(1));
   end
endmodule

// File: rtl/stk_call_seq.sv
module stk_call_seq
   import stk_call_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int STEP_W = 3,
   parameter int PAGE_TAG_W = 5,
   parameter logic [PAGE_TAG_W-1:0] PAGE_TAG = 5'b00001,
   parameter int TBL_IDX_W = 5,
   parameter int TBL_GAP_W = 8,
   parameter logic [ADDR_W-1:0] VEC_ADDR = 16'h003E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        cmd,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [ADDR_W-1:0] opnd,
   input  logic              tbl_page,
   input  logic [ADDR_W-1:0] psw_in,
   input  logic [ADDR_W-1:0] sp_in,
   input  logic              ie_in,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic              mem_re,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] pc_out,
   output logic [ADDR_W-1:0] sp_out,
   output logic [ADDR_W-1:0] psw_out,
   output logic              ie_out
);
   localparam int PC_W  = 2 * DATA_W;
   localparam int LANES = PC_W / DATA_W;

   if (PC_W != ADDR_W) begin : g_bad_width
      $error("address width must equal two data bytes");
   end
   if (TBL_IDX_W + TBL_GAP_W + 1 > ADDR_W) begin : g_bad_tbl
      $error("table address does not fit");
   end
   if (PAGE_TAG_W >= ADDR_W || STEP_W < 3) begin : g_bad_misc
      $error("page tag or step counter width out of range");
   end

   typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN, S_DONE} state_e;

   state_e            st;
   logic [STEP_W-1:0] step;
   cmd_e              cmd_q;
   logic [ADDR_W-1:0] sp_base, ret_q, opnd_q, sp_w, sp_new, ret_new, dest_new;
   logic              page_q, ie_w, rd_pend, accept;
   logic [1:0]        rd_dst_q;
   logic [PC_W-1:0]   pc_w, psw_w;
   cmd_e              cmd_in;
   acc_e              acc;
   dst_e              p_dst;
   logic              p_last;

   assign cmd_in = cmd_e'(cmd);
   assign accept = start && (st == S_IDLE || st == S_DONE);

   stk_call_tgt #(.AW(ADDR_W), .PTW(PAGE_TAG_W), .PTAG(PAGE_TAG)) u_tgt (
      .cmd (cmd_in),
      .pc  (pc_in),
      .opnd(opnd),
      .ret (ret_new),
      .dest(dest_new)
   );

   stk_call_plan #(
      .AW(ADDR_W), .DW(DATA_W), .SW(STEP_W),
      .TIW(TBL_IDX_W), .GAPW(TBL_GAP_W), .VEC(VEC_ADDR)
   ) u_plan (
      .cmd  (cmd_q),
      .step (step),
      .sp   (sp_base),
      .ret  (ret_q),
      .psw  (psw_w),
      .opnd (opnd_q),
      .page (page_q),
      .acc  (acc),
      .addr (mem_addr),
      .wdata(mem_wdata),
      .dst  (p_dst),
      .last (p_last)
   );

   always_comb begin
      unique case (cmd_in)
         CMD_BRK:  sp_new = sp_in - ADDR_W'(4);
         CMD_RET:  sp_new = sp_in + ADDR_W'(2);
         CMD_RETI: sp_new = sp_in + ADDR_W'(4);
         default:  sp_new = sp_in - ADDR_W'(2);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         step     <= '0;
         cmd_q    <= CMD_CALL_DIR;
         sp_base  <= '0;
         ret_q    <= '0;
         opnd_q   <= '0;
         sp_w     <= '0;
         page_q   <= 1'b0;
         ie_w     <= 1'b0;
         rd_pend  <= 1'b0;
         rd_dst_q <= '0;
      end else begin
         rd_pend  <= (st == S_RUN) && (acc == ACC_RD);
         rd_dst_q <= p_dst;
         if (accept) begin
            st      <= S_RUN;
            step    <= '0;
            cmd_q   <= cmd_in;
            sp_base <= sp_in;
            ret_q   <= ret_new;
            opnd_q  <= opnd;
            page_q  <= tbl_page;
            sp_w    <= sp_new;
            ie_w    <= (cmd_in == CMD_BRK) ? 1'b0 : ie_in;
         end else begin
            unique case (st)
               S_RUN: begin
                  step <= step + STEP_W'(1);
                  if (p_last) st <= S_DRAIN;
               end
               S_DRAIN: st <= S_DONE;
               S_DONE:  st <= S_IDLE;
               default: ;
            endcase
         end
      end
   end

   // per byte lane: load at acceptance, overwrite from a returning read
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pc_w[g*DATA_W +: DATA_W]  <= '0;
            psw_w[g*DATA_W +: DATA_W] <= '0;
         end else if (accept) begin
            pc_w[g*DATA_W +: DATA_W]  <= dest_new[g*DATA_W +: DATA_W];
            psw_w[g*DATA_W +: DATA_W] <= psw_in[g*DATA_W +: DATA_W];
         end else if (rd_pend && int'(rd_dst_q[0]) == g) begin
            if (rd_dst_q[1]) psw_w[g*DATA_W +: DATA_W] <= mem_rdata;
            else             pc_w[g*DATA_W +: DATA_W]  <= mem_rdata;
         end
      end
   end

   assign busy    = (st == S_RUN) || (st == S_DRAIN);
   assign done    = (st == S_DONE);
   assign mem_we  = (st == S_RUN) && (acc == ACC_WR);
   assign mem_re  = (st == S_RUN) && (acc == ACC_RD);
   assign pc_out  = pc_w;
   assign psw_out = psw_w;
   assign sp_out  = sp_w;
   assign ie_out  = ie_w;

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(mem_we || mem_re));

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   a_r1_push_descends: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we && $past(mem_we) |-> mem_addr == $past(mem_addr) - ADDR_W'(1));

   a_r7_pop_ascends: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re && $past(mem_re) |-> mem_addr == $past(mem_addr) + ADDR_W'(1));

   a_r6_brk_clears_ie: assert property (@(posedge clk) disable iff (!rst_n)
      done && cmd_q == CMD_BRK |-> !ie_out);
endmodule

// File: tb/stk_call_seq_tb.sv
module stk_call_seq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  cmd = 3'd0;
   logic [15:0] pc_in = '0, opnd = '0, psw_in = '0, sp_in = '0;
   logic        tbl_page = 1'b0, ie_in = 1'b0;
   logic        busy, done, mem_we, mem_re, ie_out;
   logic [15:0] mem_addr, pc_out, sp_out, psw_out;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;

   int total = 0;
   int fails = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   stk_call_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .pc_in(pc_in),
      .opnd(opnd), .tbl_page(tbl_page), .psw_in(psw_in), .sp_in(sp_in),
      .ie_in(ie_in), .busy(busy), .done(done), .mem_addr(mem_addr),
      .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .pc_out(pc_out), .sp_out(sp_out),
      .psw_out(psw_out), .ie_out(ie_out)
   );

   logic [7:0] mem [logic [15:0]];

   function automatic logic [7:0] memval(logic [15:0] a);
      if (mem.exists(a)) return mem[a];
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   always @(posedge clk) begin
      if (mem_re) mem_rdata <= memval(mem_addr);
      if (mem_we) mem[mem_addr] = mem_wdata;
   end

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   typedef struct {
      bit          wr;
      logic [15:0] a;
      logic [7:0]  d;
      int          dst;
   } acc_t;

   task automatic run(input logic [2:0] c, input logic [15:0] pc, input logic [15:0] op,
                      input logic pg, input logic [15:0] psw, input logic [15:0] sp,
                      input logic ie, input bit poke, input string rq);
      acc_t q[$];
      logic [15:0] ret, epc, epsw, esp, tb;
      logic [7:0]  b;
      logic        eie;
      int          len;
      bit          ok;
      len  = (c == 3'd0) ? 3 : ((c == 3'd2 || c == 3'd5) ? 1 : 2);
      ret  = pc + 16'(len);
      epc  = pc;
      epsw = psw;
      eie  = ie;
      esp  = sp;
      tb   = {2'b00, pg, 8'h00, op[4:0]};
      if (c <= 3'd4) begin
         q.push_back('{1'b1, sp - 16'd1, ret[15:8], 0});
         q.push_back('{1'b1, sp - 16'd2, ret[7:0], 0});
         esp = sp - 16'd2;
      end
      case (c)
         3'd0, 3'd3: epc = op;
         3'd1: epc = {5'b00001, op[10:0]};
         3'd2: begin
            q.push_back('{1'b0, tb, 8'h00, 0});
            q.push_back('{1'b0, tb + 16'd1, 8'h00, 1});
         end
         3'd4: begin
            q.push_back('{1'b0, op, 8'h00, 0});
            q.push_back('{1'b0, op + 16'd1, 8'h00, 1});
         end
         3'd5: begin
            q.push_back('{1'b1, sp - 16'd1, psw[15:8], 0});
            q.push_back('{1'b1, sp - 16'd2, psw[7:0], 0});
            q.push_back('{1'b1, sp - 16'd3, ret[15:8], 0});
            q.push_back('{1'b1, sp - 16'd4, ret[7:0], 0});
            q.push_back('{1'b0, 16'h003E, 8'h00, 0});
            q.push_back('{1'b0, 16'h003F, 8'h00, 1});
            esp = sp - 16'd4;
            eie = 1'b0;
         end
         3'd6: begin
            q.push_back('{1'b0, sp, 8'h00, 0});
            q.push_back('{1'b0, sp + 16'd1, 8'h00, 1});
            esp = sp + 16'd2;
         end
         default: begin
            for (int k = 0; k < 4; k++) q.push_back('{1'b0, sp + 16'(k), 8'h00, k});
            esp = sp + 16'd4;
         end
      endcase
      @(negedge clk);
      start = 1'b1; cmd = c; pc_in = pc; opnd = op; tbl_page = pg;
      psw_in = psw; sp_in = sp; ie_in = ie;
      @(negedge clk);
      start = 1'b0;
      foreach (q[i]) begin
         ok = busy && (mem_we == q[i].wr) && (mem_re == !q[i].wr) && (mem_addr == q[i].a)
              && (!q[i].wr || mem_wdata == q[i].d);
         chk(ok, {rq, " R9 access"}, {6'd0, busy, mem_we, mem_re, mem_addr, mem_wdata},
             {6'd0, 1'b1, q[i].wr, !q[i].wr, q[i].a, q[i].d});
         if (!q[i].wr) begin
            b = memval(q[i].a);
            case (q[i].dst)
               0: epc[7:0]   = b;
               1: epc[15:8]  = b;
               2: epsw[7:0]  = b;
               default: epsw[15:8] = b;
            endcase
         end
         if (poke && i == 0) begin
            start = 1'b1; cmd = 3'd6; pc_in = 16'h0000; sp_in = 16'h0000; // R10 ignored start
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
      end
      start = 1'b0;
      chk(busy && !done && !mem_we && !mem_re, {rq, " R10 quiet cycle"},
          {28'd0, busy, done, mem_we, mem_re}, 32'h8);
      @(negedge clk);
      chk(done && !busy, {rq, " R10 done"}, {30'd0, done, busy}, 32'h2);
      chk(pc_out == epc, {rq, " pc"}, 32'(pc_out), 32'(epc));
      chk(sp_out == esp, {rq, " sp"}, 32'(sp_out), 32'(esp));
      chk(psw_out == epsw, {rq, " psw"}, 32'(psw_out), 32'(epsw));
      chk(ie_out == eie, {rq, " R6 ie"}, 32'(ie_out), 32'(eie));
      @(negedge clk);
      chk(!done && !busy, {rq, " R10 pulse"}, {30'd0, done, busy}, 32'h0);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         total++;
         fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !mem_we && !mem_re, "reset R10", {28'd0, busy, done, mem_we, mem_re}, 32'h0);
      chk(pc_out == 16'h0 && sp_out == 16'h0, "reset outputs", {pc_out, sp_out}, 32'h0);

      // R1 R2 direct call
      run(3'd0, 16'h1234, 16'hABCD, 1'b0, 16'h0F0F, 16'h8000, 1'b1, 1'b0, "R1 R2 direct");
      // R7 return to the address pushed above
      run(3'd6, 16'h5555, 16'h0000, 1'b0, 16'h1111, 16'h7FFE, 1'b1, 1'b0, "R7 return");
      chk(pc_out == 16'h1237, "R7 pops pushed address", 32'(pc_out), 32'h1237);
      // R2 page call with all offset bits set
      run(3'd1, 16'h3000, 16'hFFFF, 1'b0, 16'h2222, 16'h4000, 1'b0, 1'b0, "R2 page");
      chk(pc_out == 16'h0FFF, "R2 page target", 32'(pc_out), 32'h0FFF);
      // R3 table calls, top index with page bit set, and a low index
      mem[16'h201F] = 8'h34; mem[16'h2020] = 8'h12;
      run(3'd2, 16'h2000, 16'h001F, 1'b1, 16'h3333, 16'h5000, 1'b1, 1'b0, "R3 table top");
      chk(pc_out == 16'h1234, "R3 table target", 32'(pc_out), 32'h1234);
      run(3'd2, 16'h2100, 16'hFFE5, 1'b0, 16'h3333, 16'h5000, 1'b0, 1'b0, "R3 table low");
      // R4 register and register-indirect calls, with an ignored start (R10)
      run(3'd3, 16'h0700, 16'hBEEF, 1'b0, 16'h4444, 16'h6000, 1'b1, 1'b1, "R4 register");
      mem[16'h4000] = 8'hCD; mem[16'h4001] = 8'hAB;
      run(3'd4, 16'h0800, 16'h4000, 1'b0, 16'h4444, 16'h6000, 1'b0, 1'b0, "R4 indirect");
      chk(pc_out == 16'hABCD, "R4 indirect target", 32'(pc_out), 32'hABCD);
      // R5 R6 break then R8 return from interrupt
      mem[16'h003E] = 8'h00; mem[16'h003F] = 8'h90;
      run(3'd5, 16'h0456, 16'h0000, 1'b0, 16'hA5C3, 16'h6000, 1'b1, 1'b1, "R5 R6 break");
      chk(pc_out == 16'h9000, "R6 vector", 32'(pc_out), 32'h9000);
      run(3'd7, 16'h9000, 16'h0000, 1'b0, 16'h0000, 16'h5FFC, 1'b1, 1'b0, "R8 reti");
      chk(pc_out == 16'h0457 && psw_out == 16'hA5C3, "R8 restored", {pc_out, psw_out}, 32'h0457A5C3);
      // R11 wrap below zero and back
      run(3'd3, 16'hFFFF, 16'h0100, 1'b0, 16'h0001, 16'h0001, 1'b0, 1'b0, "R11 push wrap");
      run(3'd6, 16'h0100, 16'h0000, 1'b0, 16'h0001, 16'hFFFF, 1'b0, 1'b0, "R11 pop wrap");
      chk(pc_out == 16'h0001 && sp_out == 16'h0001, "R11 wrap result", {pc_out, sp_out}, 32'h00010001);
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule